// File: doc/BRIEF.md
# I2C serial EEPROM slave front end

This block is the bus side of a small byte-addressed nonvolatile memory of 512 or 1024 bytes. It watches the raw SCL and SDA lines through two-flop synchronisers, finds start and stop conditions on the system clock, and decodes the device-select byte. The byte is accepted only when its prefix matches and its select bits match two strap pins. In place of further select bits, that byte also carries the upper memory address bits. The block acknowledges by pulling SDA low through an open-drain enable. It carries out single-byte writes, multi-byte page writes, reads from the current address, random reads and sequential reads.

The address counter and the page buffer sit outside the block. Three interfaces connect them. `addr_ld` is a one-cycle pulse that loads a full address. Write bytes leave on a valid/ready stream. The slave raises `wr_valid` with the byte after the eighth SCL rise and holds `wr_data` until `wr_ready` is seen. A byte that has not been accepted by the SCL fall that opens the acknowledge slot is dropped and NACKed, so back-pressure shows on the bus as a NACK. Read bytes come in on a second stream. The slave raises `rd_ready` to ask for the byte at the counter, and the counter answers with `rd_valid` and `rd_data`. If no answer arrives before the first bit must be driven, the byte goes out as 0xFF. A stop that ends a transaction with at least one accepted data byte pulses `wr_commit`. The owner of the memory then runs its write cycle and holds `write_busy` high until the cycle is done.

The system clock must run at least ten times the SCL rate. `MEM_BYTES` selects the 512-byte or the 1024-byte layout of the select byte. In the 1024-byte layout, bit 3 is compared with `strap_sel[1]`, and bits 2:1 become address bits 9:8.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset, `sda_oe`, `addr_ld`, `wr_valid`, `wr_commit` and `rd_ready` are all low.
- R2: A select byte whose bits 7:4 differ from 1010 is not acknowledged. The slave then ignores the bus until the next start: later bytes get no acknowledge and no strobes.
- R3: With MEM_BYTES=512, select-byte bits 3 and 2 must equal `strap_sel[1]` and `strap_sel[0]`, or the byte is not acknowledged. Bit 1 becomes address bit 8, and bit 0 is the direction bit (1 = read).
- R4: After an acknowledged write-direction select byte, the next byte is acknowledged and `addr_ld` pulses once with `addr_ld_val` = {upper bits from the select byte, received byte}.
- R5: Each following byte is offered on `wr_valid`/`wr_data`. It is acknowledged when accepted by the start of the acknowledge slot, and NACKed and dropped otherwise. Several bytes may follow in one transaction.
- R6: A stop pulses `wr_commit` for one cycle only if the transaction had at least one accepted data byte. An address-only write, such as the dummy write before a random read, gives no pulse.
- R7: While `write_busy` is high, a matching select byte is not acknowledged. Once it falls, the same byte is acknowledged again.
- R8: After an acknowledged read-direction select byte, the slave requests a byte on `rd_ready` and sends it MSB first, changing SDA only after SCL falls. A byte not supplied in time reads as 0xFF.
- R9: A master ACK after a read byte causes one new request and the next byte. A master NACK causes no further request and releases SDA.
- R10: A start in the middle of any byte abandons that byte without strobes and restarts select-byte reception.
- R11: `sda_oe` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| strap_sel | input | 2 | Hard-wired select straps compared with the select byte |
| write_busy | input | 1 | High while the memory's internal write cycle runs |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_ld | output | 1 | One-cycle pulse that loads the address counter |
| addr_ld_val | output | ADDR_W (9) | Address to load |
| wr_valid | output | 1 | Write byte available |
| wr_ready | input | 1 | Page buffer accepts the write byte |
| wr_data | output | 8 | Write byte |
| wr_commit | output | 1 | One-cycle pulse at a stop that ends a write with data |
| rd_ready | output | 1 | Request for the byte at the counter |
| rd_valid | input | 1 | Read byte supplied |
| rd_data | input | 8 | Read byte |

## Verification
The hardest case to reach is a start that arrives with a byte only half shifted in. Ordinary master tasks always finish a byte before they issue a start or a stop. The bench therefore has a task that clocks only four bits of a word address and leaves SCL low. It then raises a repeated start at once, follows it with a read-direction select byte, and checks three things: the read gets an acknowledge, no address load occurred, and the byte read back comes from the address loaded earlier. Acknowledge polling is reached by opening a new transaction right after a committed write, while the bench's model of the memory still holds `write_busy` high.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  localparam logic [3:0] DEV_PREFIX = 4'b1010;
  localparam int         BYTE_BITS  = 8;

  typedef enum logic [2:0] {
    S_IDLE,   // ignoring the bus until a start
    S_RX,     // shifting in a byte from the master
    S_ACK,    // ninth clock after a byte
    S_TX,     // shifting out a read byte
    S_MACK    // sampling the master's acknowledge
  } st_t;

  typedef enum logic [1:0] {
    PH_DEV,   // select byte
    PH_WADR,  // word address byte
    PH_WDAT,  // write data bytes
    PH_RD     // read data bytes
  } ph_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-1:0], din};
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic scl_lvl,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic bus_start,
  output logic bus_stop
);
  // Both lines pass through equal-depth synchronisers, so the SDA edge
  // lines up with the SCL level that held when it happened.
  assign bus_start = sda_fall & scl_lvl;
  assign bus_stop  = sda_rise & scl_lvl;
endmodule

// File: rtl/i2c_dev_match.sv
module i2c_dev_match
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W = 9,
  localparam int HI_W  = ADDR_W - BYTE_BITS
) (
  input  logic [7:1]      dev_bits,
  input  logic [1:0]      strap,
  output logic            hit,
  output logic [HI_W-1:0] hi
);
  generate
    if (HI_W == 1) begin : g_two_straps
      assign hit = (dev_bits[7:4] == DEV_PREFIX) && (dev_bits[3:2] == strap);
      assign hi  = dev_bits[1:1];
    end else begin : g_one_strap
      logic unused_strap;
      assign unused_strap = strap[0];
      assign hit = (dev_bits[7:4] == DEV_PREFIX) && (dev_bits[3] == strap[1]);
      assign hi  = dev_bits[2:1];
    end
  endgenerate
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter int MEM_BYTES   = 512,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(MEM_BYTES),
  localparam int HI_W       = ADDR_W - BYTE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        strap_sel,
  input  logic              write_busy,
  output logic              sda_oe,
  output logic              addr_ld,
  output logic [ADDR_W-1:0] addr_ld_val,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [7:0]        wr_data,
  output logic              wr_commit,
  output logic              rd_ready,
  input  logic              rd_valid,
  input  logic [7:0]        rd_data
);
  // index 1 carries SCL, index 0 carries SDA
  logic [1:0] raw_in, lv, rs, fl;
  assign raw_in = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_in[g]),
      .lvl  (lv[g]),
      .rise (rs[g]),
      .fall (fl[g])
    );
  end

  logic scl_lvl, scl_rise, scl_fall, sda_lvl;
  assign scl_lvl  = lv[1];
  assign scl_rise = rs[1];
  assign scl_fall = fl[1];
  assign sda_lvl  = lv[0];

  logic bus_start, bus_stop;
  i2c_bus_cond u_cond (
    .scl_lvl  (scl_lvl),
    .sda_rise (rs[0]),
    .sda_fall (fl[0]),
    .bus_start(bus_start),
    .bus_stop (bus_stop)
  );

  st_t            st;
  ph_t            ph;
  logic [3:0]     cnt;
  logic [7:0]     sh;
  logic [7:0]     rbuf;
  logic           rw;
  logic [HI_W-1:0] hi;
  logic           wr_taken, wrote_any, rd_req;

  logic            dev_hit;
  logic [HI_W-1:0] dev_hi;
  i2c_dev_match #(.ADDR_W(ADDR_W)) u_match (
    .dev_bits(sh[7:1]),
    .strap   (strap_sel),
    .hit     (dev_hit),
    .hi      (dev_hi)
  );

  logic       wr_hs, rd_hs;
  logic [7:0] rd_next;
  assign wr_hs    = wr_valid & wr_ready;
  assign rd_hs    = rd_req & rd_valid;
  assign rd_next  = rd_hs ? rd_data : rbuf;
  assign rd_ready = rd_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      ph          <= PH_DEV;
      cnt         <= '0;
      sh          <= '0;
      rbuf        <= '1;
      rw          <= 1'b0;
      hi          <= '0;
      sda_oe      <= 1'b0;
      addr_ld     <= 1'b0;
      addr_ld_val <= '0;
      wr_valid    <= 1'b0;
      wr_data     <= '0;
      wr_taken    <= 1'b0;
      wrote_any   <= 1'b0;
      wr_commit   <= 1'b0;
      rd_req      <= 1'b0;
    end else begin
      addr_ld   <= 1'b0;
      wr_commit <= 1'b0;
      if (wr_hs) begin
        wr_valid <= 1'b0;
        wr_taken <= 1'b1;
      end
      if (rd_hs) begin
        rd_req <= 1'b0;
        rbuf   <= rd_data;
      end

      if (bus_stop) begin
        st        <= S_IDLE;
        sda_oe    <= 1'b0;
        wr_valid  <= 1'b0;
        rd_req    <= 1'b0;
        wr_commit <= wrote_any;
        wrote_any <= 1'b0;
      end else if (bus_start) begin
        st        <= S_RX;
        ph        <= PH_DEV;
        cnt       <= '0;
        sda_oe    <= 1'b0;
        wr_valid  <= 1'b0;
        rd_req    <= 1'b0;
        wrote_any <= 1'b0;
      end else begin
        unique case (st)
          S_RX: begin
            if (scl_rise && cnt != 4'd8) begin
              sh  <= {sh[6:0], sda_lvl};
              cnt <= cnt + 4'd1;
              if (cnt == 4'd7 && ph == PH_WDAT) begin
                wr_valid <= 1'b1;
                wr_data  <= {sh[6:0], sda_lvl};
                wr_taken <= 1'b0;
              end
            end else if (scl_fall && cnt == 4'd8) begin
              unique case (ph)
                PH_DEV: begin
                  if (dev_hit && !write_busy) begin
                    sda_oe <= 1'b1;
                    st     <= S_ACK;
                    rw     <= sh[0];
                    hi     <= dev_hi;
                    if (sh[0]) begin
                      rd_req <= 1'b1;
                      rbuf   <= '1;
                    end
                  end else begin
                    st <= S_IDLE;
                  end
                end
                PH_WADR: begin
                  sda_oe      <= 1'b1;
                  st          <= S_ACK;
                  addr_ld     <= 1'b1;
                  addr_ld_val <= {hi, sh};
                end
                default: begin
                  if (wr_taken || wr_hs) begin
                    sda_oe    <= 1'b1;
                    st        <= S_ACK;
                    wrote_any <= 1'b1;
                  end else begin
                    st       <= S_IDLE;
                    wr_valid <= 1'b0;
                  end
                end
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (ph == PH_RD || (ph == PH_DEV && rw)) begin
                st     <= S_TX;
                ph     <= PH_RD;
                sda_oe <= ~rd_next[7];
                rbuf   <= rd_next;
                rd_req <= 1'b0;
              end else begin
                st     <= S_RX;
                sda_oe <= 1'b0;
                ph     <= (ph == PH_DEV) ? PH_WADR : PH_WDAT;
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0;
                st     <= S_MACK;
              end else begin
                sda_oe <= ~rbuf[6];
                rbuf   <= {rbuf[6:0], 1'b1};
                cnt    <= cnt + 4'd1;
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              if (!sda_lvl) begin
                st     <= S_ACK;
                rd_req <= 1'b1;
                rbuf   <= '1;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk
  import i2c_mem_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_lvl,
  input logic       sda_oe,
  input logic       write_busy,
  input st_t        st,
  input ph_t        ph,
  input logic       addr_ld,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [7:0] wr_data,
  input logic       wr_commit,
  input logic       bus_stop
);
  // R11
  sda_only_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_lvl);

  // R7
  no_ack_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && ph == PH_DEV) |-> !$past(write_busy));

  // R6
  commit_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(bus_stop));

  // R5
  wr_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> $stable(wr_data));

  // R4
  addr_ld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ld |=> !addr_ld);

  // R2
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);
endmodule

bind i2c_mem_slave i2c_mem_slave_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_lvl   (scl_lvl),
  .sda_oe    (sda_oe),
  .write_busy(write_busy),
  .st        (st),
  .ph        (ph),
  .addr_ld   (addr_ld),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_data   (wr_data),
  .wr_commit (wr_commit),
  .bus_stop  (bus_stop)
);

// File: tb/i2c_mem_slave_bench.sv
module i2c_mem_slave_bench;
  localparam int         Q     = 8;
  localparam logic [1:0] STRAP = 2'b01;
  localparam logic [7:0] DEVW  = 8'hA4;  // prefix 1010, straps 01, hi 0, write

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  always #4 clk = ~clk;

  logic       sda_oe, addr_ld, wr_valid, wr_commit, rd_ready;
  logic [8:0] addr_ld_val;
  logic [7:0] wr_data;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       accept_en = 1'b1;
  logic       resp_en = 1'b1;
  int         busy_t;
  logic       sda_line;
  assign sda_line = sda_m & ~sda_oe;

  i2c_mem_slave u_i2c_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_sel(STRAP), .write_busy(busy_t != 0), .sda_oe(sda_oe),
    .addr_ld(addr_ld), .addr_ld_val(addr_ld_val),
    .wr_valid(wr_valid), .wr_ready(accept_en), .wr_data(wr_data),
    .wr_commit(wr_commit), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );

  // model of the address counter and memory outside the block
  logic [7:0] mem [0:511];
  logic [8:0] ptr, last_ld;
  int n_ld, n_wr, n_rd, n_commit;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] <= i[7:0] ^ 8'h3C;
      ptr <= '0; last_ld <= '0; rd_valid <= 1'b0; rd_data <= '0;
      n_ld <= 0; n_wr <= 0; n_rd <= 0; n_commit <= 0; busy_t <= 0;
    end else begin
      rd_valid <= 1'b0;
      if (addr_ld) begin
        ptr <= addr_ld_val; last_ld <= addr_ld_val; n_ld <= n_ld + 1;
      end else if (wr_valid && accept_en) begin
        mem[ptr] <= wr_data; ptr <= {ptr[8:4], ptr[3:0] + 4'd1}; n_wr <= n_wr + 1;
      end else if (rd_ready && !rd_valid && resp_en) begin
        rd_valid <= 1'b1; rd_data <= mem[ptr]; ptr <= ptr + 9'd1; n_rd <= n_rd + 1;
      end
      if (wr_commit) begin
        n_commit <= n_commit + 1; busy_t <= 2000;
      end else if (busy_t != 0) busy_t <= busy_t - 1;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bstop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = ~sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      b[i] = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = ~mack; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic wait_idle();
    while (busy_t != 0) tick(1);
    tick(Q);
  endtask

  task automatic t_reset();
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 rd_ready", rd_ready, 0);
    chk("R1 wr_valid", wr_valid, 0);
    chk("R1 addr_ld/wr_commit", {addr_ld, wr_commit}, 0);
  endtask

  task automatic t_mismatch();
    logic a; int ld0 = n_ld;
    bstart(); send_byte(8'hB4, a); chk("R2 bad prefix nack", a, 0); bstop();
    bstart(); send_byte(8'hA0, a); chk("R3 strap mismatch nack", a, 0);
    send_byte(8'h12, a); chk("R2 ignored byte nack", a, 0);
    chk("R2 no addr load", n_ld - ld0, 0); bstop();
  endtask

  task automatic t_byte_write();
    logic a; int ld0 = n_ld, c0 = n_commit;
    bstart(); send_byte(DEVW | 8'h02, a); chk("R2 match ack", a, 1);
    send_byte(8'h23, a); chk("R4 word addr ack", a, 1);
    chk("R4 one load", n_ld - ld0, 1);
    chk("R3 R4 load value", last_ld, 9'h123);
    send_byte(8'h5A, a); chk("R5 data ack", a, 1);
    bstop(); tick(4);
    chk("R6 commit pulse", n_commit - c0, 1);
    chk("R5 byte stored", mem[9'h123], 8'h5A);
  endtask

  task automatic t_busy_poll();
    logic a; int c0 = n_commit;
    bstart(); send_byte(DEVW, a); chk("R7 nack while busy", a, 0); bstop();
    wait_idle();
    bstart(); send_byte(DEVW, a); chk("R7 ack after busy", a, 1); bstop(); tick(4);
    chk("R6 no commit without data", n_commit - c0, 0);
  endtask

  task automatic t_page_write();
    logic a; int w0 = n_wr;
    bstart(); send_byte(DEVW, a); send_byte(8'h0E, a);
    send_byte(8'h11, a); chk("R5 page byte0 ack", a, 1);
    send_byte(8'h22, a); send_byte(8'h33, a); chk("R5 page byte2 ack", a, 1);
    bstop(); tick(4);
    chk("R5 three bytes offered", n_wr - w0, 3);
    chk("R5 first page byte", mem[9'h00E], 8'h11);
    chk("R5 third page byte", mem[9'h000], 8'h33);
    wait_idle();
  endtask

  task automatic t_random_read();
    logic a; logic [7:0] d; int r0 = n_rd, c0 = n_commit;
    bstart(); send_byte(DEVW, a); send_byte(8'h0E, a);
    bstart(); send_byte(DEVW | 8'h01, a); chk("R8 read select ack", a, 1);
    recv_byte(1'b1, d); chk("R8 random read byte", d, 8'h11);
    recv_byte(1'b1, d); chk("R9 sequential byte", d, 8'h22);
    recv_byte(1'b0, d); chk("R9 third byte", d, 8'h2C);
    tick(4);
    chk("R9 no request after nack", rd_ready, 0);
    chk("R9 sda released", sda_oe, 0);
    bstop(); tick(4);
    chk("R9 request count", n_rd - r0, 3);
    chk("R6 dummy write no commit", n_commit - c0, 0);
  endtask

  task automatic t_current_read();
    logic a; logic [7:0] d;
    bstart(); send_byte(DEVW | 8'h03, a); recv_byte(1'b0, d); bstop();
    chk("R8 current address byte", d, 8'h2D);
  endtask

  task automatic t_no_data();
    logic a; logic [7:0] d;
    resp_en = 1'b0;
    bstart(); send_byte(DEVW | 8'h01, a); recv_byte(1'b0, d); bstop();
    chk("R8 unanswered read is FF", d, 8'hFF);
    resp_en = 1'b1;
  endtask

  task automatic t_backpressure();
    logic a; int c0 = n_commit;
    accept_en = 1'b0;
    bstart(); send_byte(DEVW, a); send_byte(8'h40, a);
    send_byte(8'h77, a); chk("R5 refused byte nack", a, 0);
    bstop(); tick(4);
    chk("R6 no commit for refused byte", n_commit - c0, 0);
    chk("R5 memory untouched", mem[9'h040], 8'h7C);
    accept_en = 1'b1;
  endtask

  task automatic t_abort();
    logic a; logic [7:0] d; int ld0 = n_ld;
    bstart(); send_byte(DEVW, a);
    send_bits(8'h30, 4);
    bstart(); send_byte(DEVW | 8'h01, a); chk("R10 select after abort ack", a, 1);
    recv_byte(1'b0, d); bstop();
    chk("R10 no load from partial byte", n_ld - ld0, 0);
    chk("R10 read from old address", d, 8'h7C);
  endtask

  initial begin
    tick(5); rst_n = 1'b1; tick(5);
    t_reset();
    t_mismatch();
    t_byte_write();
    t_busy_poll();
    t_page_write();
    t_random_read();
    t_current_read();
    t_no_data();
    t_backpressure();
    t_abort();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule